// File: doc/BRIEF.md
# Input Clock Loss-of-Signal Monitor

The monitor watches one incoming clock for missing pulses. In the monitored clock's own domain a programmable divider brings the clock down to a slow square wave. A two-flop synchronizer carries that wave into a fast reference clock domain. There the block looks for level changes between consecutive samples and counts the reference cycles since the last change it saw.

When that count reaches twice the expected number of samples per divided half period, the block declares a loss of signal. The alarm is sticky. It clears only after the input has been seen as healthy for a programmed number of consecutive reference cycles. A new missing-edge condition during that window keeps the alarm high and starts the window again from zero.

Reset leaves the alarm asserted and treats the input as already silent. A live input must therefore pass validation before the alarm drops. All configuration inputs are static: change them only while reset is held.

Top module: `los_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first reference edge after it rises, `los_alarm` is 1. After reset the input counts as missing until the first transition of the divided clock has been recognised.
- R2: Reset puts the divided clock low with its divider count at zero. After reset the divided clock inverts on every `cfg_div_half`-th rising edge of `mon_clk`. A value of 0 behaves as 1.
- R3: The divided clock is sampled on `ref_clk` through two flops. A transition is recognised when the second-stage sample differs from the sample taken one cycle before it. Recognition clears the no-edge count on the next reference edge.
- R4: Let `los_alarm` be low, and let the last divided-clock transition occur just before reference edge j. `los_alarm` then rises exactly on reference edge j + 2·`cfg_nom_half` + 3.
- R5: `los_alarm` does not rise while every no-edge count stays below 2·`cfg_nom_half`.
- R6: Once the no-edge count is back below the threshold, `los_alarm` falls after `cfg_valid_len` consecutive reference cycles without a missing-edge condition. A value of 0 behaves as 1.
- R7: A missing-edge condition during validation resets the validation count to zero. The full `cfg_valid_len` cycles are then needed again.
- R8: While the no-edge count stays at or above the threshold, `los_alarm` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| mon_clk | input | 1 | Monitored input clock |
| cfg_div_half | input | DIV_W | Monitored rising edges per divided half period |
| cfg_nom_half | input | NOM_W | Expected reference samples between divided transitions |
| cfg_valid_len | input | VAL_W | Reference cycles of good input needed to clear the alarm |
| los_alarm | output | 1 | Sticky loss-of-signal alarm, high = lost |

## Verification
The hardest case to reach from the ports is a dropout that starts while a validation window is already partly done. The no-edge count must cross the threshold after some validation cycles have run but before they finish. The bench stops the monitored clock at random points in the run and restarts it after random durations. One directed sequence lets validation run about halfway and then holds the clock for just over the threshold. The bench model tracks the expected alarm cycle by cycle, so an early clear after such a restart shows up as a mismatch tagged with the validation-restart requirement.

// File: rtl/los_pkg.sv
// Package shared by the loss-of-signal monitor.
// Holds the default widths and a helper that maps a zero setting to one.
package los_pkg;
    localparam int unsigned DEF_DIV_W = 8;
    localparam int unsigned DEF_NOM_W = 12;
    localparam int unsigned DEF_VAL_W = 16;

    // Treat a zero configuration count as one; widths up to 32 bits.
    function automatic logic [31:0] at_least_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction
endpackage

// File: rtl/los_divider.sv
// Divides the monitored clock in its own domain.
// Assumes rst_n is held low for several monitored clock edges.
// The output inverts once every cfg_half rising edges (0 treated as 1).
module los_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half,
    output logic             div_out
);
    import los_pkg::*;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    // Index of the final edge in a half period.
    always_comb begin
        last = DIV_W'(at_least_one(32'(cfg_half)) - 32'd1);
    end

    // Count monitored edges and invert the output at the end of each half period.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            div_out <= 1'b0;
        end else if (cnt >= last) begin
            cnt     <= '0;
            div_out <= ~div_out;
        end else begin
            cnt     <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/los_edge_watch.sv
// Brings the divided clock into the reference domain and counts the cycles since its last level change.
// Assumes the divided clock is slow against ref_clk.
// After reset the count starts saturated, so the input counts as missing until an edge arrives.
module los_edge_watch #(
    parameter int unsigned NOM_W = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             div_in,
    input  logic [NOM_W-1:0] cfg_nom_half,
    output logic             edge_seen,
    output logic             miss,
    output logic [NOM_W:0]   gap
);
    localparam int unsigned GAP_W = NOM_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [GAP_W-1:0]       thresh;

    // Synchronizer chain; bit 0 is the first stage.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the asynchronous divided clock.
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= div_in;
                end
            end else begin : g_next
                // Later stages shift the sample along.
                always_ff @(posedge ref_clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Hold the previous synchronized sample for edge comparison.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Edge flag, threshold and miss decision.
    always_comb begin
        edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
        thresh    = {cfg_nom_half, 1'b0};
        miss      = (gap >= thresh);
    end

    // Cycles since the last recognised edge, saturating at the threshold.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)            gap <= '1;
        else if (edge_seen)    gap <= '0;
        else if (gap < thresh) gap <= gap + 1'b1;
    end
endmodule

// File: rtl/los_validator.sv
// Sticky alarm with a validation timer.
// Assumes miss is synchronous to ref_clk.
// Each missing cycle sets the alarm and zeroes the timer. The alarm drops after cfg_valid_len clean cycles in a row (0 treated as 1).
module los_validator #(
    parameter int unsigned VAL_W = 16
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             miss,
    input  logic [VAL_W-1:0] cfg_valid_len,
    output logic             alarm,
    output logic [VAL_W-1:0] vcnt
);
    import los_pkg::*;

    logic [VAL_W-1:0] last;

    // Final count of a validation window.
    always_comb begin
        last = VAL_W'(at_least_one(32'(cfg_valid_len)) - 32'd1);
    end

    // Alarm and validation count update.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            alarm <= 1'b1;
            vcnt  <= '0;
        end else if (miss) begin
            alarm <= 1'b1;
            vcnt  <= '0;
        end else if (alarm) begin
            if (vcnt >= last) begin
                alarm <= 1'b0;
                vcnt  <= '0;
            end else begin
                vcnt  <= vcnt + 1'b1;
            end
        end else begin
            vcnt <= '0;
        end
    end
endmodule

// File: rtl/los_monitor.sv
// Top level of the loss-of-signal monitor.
// Divider in the mon_clk domain; edge watch and validator in the ref_clk domain.
// Assumes the configuration inputs change only while rst_n is low.
module los_monitor #(
    parameter int unsigned DIV_W = los_pkg::DEF_DIV_W,
    parameter int unsigned NOM_W = los_pkg::DEF_NOM_W,
    parameter int unsigned VAL_W = los_pkg::DEF_VAL_W
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic [DIV_W-1:0] cfg_div_half,
    input  logic [NOM_W-1:0] cfg_nom_half,
    input  logic [VAL_W-1:0] cfg_valid_len,
    output logic             los_alarm
);
    logic             div_clk;
    logic             edge_seen;
    logic             miss;
    logic [NOM_W:0]   gap;
    logic [VAL_W-1:0] vcnt;

    los_divider #(.DIV_W(DIV_W)) u_div (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .cfg_half (cfg_div_half),
        .div_out  (div_clk)
    );

    los_edge_watch #(.NOM_W(NOM_W), .SYNC_STAGES(2)) u_watch (
        .ref_clk      (ref_clk),
        .rst_n        (rst_n),
        .div_in       (div_clk),
        .cfg_nom_half (cfg_nom_half),
        .edge_seen    (edge_seen),
        .miss         (miss),
        .gap          (gap)
    );

    los_validator #(.VAL_W(VAL_W)) u_val (
        .ref_clk       (ref_clk),
        .rst_n         (rst_n),
        .miss          (miss),
        .cfg_valid_len (cfg_valid_len),
        .alarm         (los_alarm),
        .vcnt          (vcnt)
    );
endmodule

// File: rtl/los_monitor_chk.sv
// Checker for the loss-of-signal monitor, bound to the top level.
module los_monitor_chk #(
    parameter int unsigned NOM_W = 12,
    parameter int unsigned VAL_W = 16
) (
    input logic             ref_clk,
    input logic             rst_n,
    input logic             los_alarm,
    input logic             edge_seen,
    input logic             miss,
    input logic [NOM_W:0]   gap,
    input logic [VAL_W-1:0] vcnt,
    input logic [VAL_W-1:0] cfg_valid_len
);
    AST_RESET_ALARM: assert property (@(posedge ref_clk) !rst_n |=> los_alarm); // R1
    AST_EDGE_CLEARS_GAP: assert property (@(posedge ref_clk) disable iff (!rst_n) edge_seen |=> (gap == '0)); // R3
    AST_MISS_RAISES: assert property (@(posedge ref_clk) disable iff (!rst_n) miss |=> los_alarm); // R8
    AST_FALL_AFTER_CLEAN: assert property (@(posedge ref_clk) disable iff (!rst_n) $fell(los_alarm) |-> !$past(miss)); // R6
    AST_VALID_RESTART: assert property (@(posedge ref_clk) disable iff (!rst_n) miss |=> (vcnt == '0)); // R7
    AST_VCNT_BOUND: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (vcnt < ((cfg_valid_len == '0) ? VAL_W'(1) : cfg_valid_len))); // R6
endmodule

bind los_monitor los_monitor_chk #(.NOM_W(NOM_W), .VAL_W(VAL_W)) chk_i (
    .ref_clk       (ref_clk),
    .rst_n         (rst_n),
    .los_alarm     (los_alarm),
    .edge_seen     (edge_seen),
    .miss          (miss),
    .gap           (gap),
    .vcnt          (vcnt),
    .cfg_valid_len (cfg_valid_len)
);

// File: tb/los_monitor_tb_top.sv
module los_monitor_tb_top;
    localparam int DIV_W = 8;
    localparam int NOM_W = 12;
    localparam int VAL_W = 16;

    logic             ref_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mon_clk = 1'b0;
    logic [DIV_W-1:0] cfg_div_half = 8'd1;
    logic [NOM_W-1:0] cfg_nom_half = 12'd2;
    logic [VAL_W-1:0] cfg_valid_len = 16'd4;
    logic             los_alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    los_monitor #(.DIV_W(DIV_W), .NOM_W(NOM_W), .VAL_W(VAL_W)) dut_i (
        .ref_clk       (ref_clk),
        .rst_n         (rst_n),
        .mon_clk       (mon_clk),
        .cfg_div_half  (cfg_div_half),
        .cfg_nom_half  (cfg_nom_half),
        .cfg_valid_len (cfg_valid_len),
        .los_alarm     (los_alarm)
    );

    always #4 ref_clk = ~ref_clk;

    // Monitored clock source: toggles on ref falling edges, mon_half falls per half period
    bit mon_en = 0;
    int mon_half = 1;
    int mon_tick = 0;
    int m_dcnt = 0;
    bit m_dlev = 0;

    always @(negedge ref_clk) begin
        if (mon_en) begin
            mon_tick++;
            if (mon_tick >= mon_half) begin
                mon_tick = 0;
                mon_clk = ~mon_clk;
                if (mon_clk) begin
                    // R2: divider model, 0 treated as 1
                    if (!rst_n) begin
                        m_dcnt = 0; m_dlev = 0;
                    end else if (m_dcnt >= eff(cfg_div_half) - 1) begin
                        m_dcnt = 0; m_dlev = ~m_dlev;
                    end else m_dcnt++;
                end
            end
        end
    end

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Expected-behaviour model in the reference domain
    bit e_s1, e_s2, e_s3;
    int e_gap;
    bit e_alarm;
    int e_vcnt;
    bit e_restarted;
    bit check_on = 0;

    task automatic check(input bit got, input bit exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: los_alarm=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    always begin
        @(posedge ref_clk);
        #1;
        if (!rst_n) begin
            e_s1 = 0; e_s2 = 0; e_s3 = 0;
            e_gap = 1 << 20; e_alarm = 1; e_vcnt = 0; e_restarted = 0;
            if (check_on) check(los_alarm, 1'b1, "R1");
        end else begin
            bit was_alarm;
            bit ed;
            bit mi;
            int thr;
            string tag;
            thr = 2 * cfg_nom_half;
            was_alarm = e_alarm;
            ed = e_s2 ^ e_s3;                 // R3: compare consecutive samples
            mi = (e_gap >= thr);              // R4, R5 threshold at twice nominal
            if (mi) begin
                if (e_alarm && e_vcnt != 0) e_restarted = 1; // R7
                e_alarm = 1; e_vcnt = 0;
            end else if (e_alarm) begin
                if (e_vcnt >= eff(cfg_valid_len) - 1) begin
                    e_alarm = 0; e_vcnt = 0;  // R6
                end else e_vcnt++;
            end else e_vcnt = 0;
            if (ed) e_gap = 0;
            else if (e_gap < thr) e_gap++;
            e_s3 = e_s2; e_s2 = e_s1; e_s1 = m_dlev;
            if (!was_alarm && e_alarm) begin tag = "R4"; e_restarted = 0; end
            else if (was_alarm && !e_alarm) begin tag = "R6"; e_restarted = 0; end
            else if (e_alarm && e_restarted) tag = "R7";
            else if (e_alarm) tag = "R8";
            else tag = "R5";
            if (check_on) check(los_alarm, e_alarm, tag);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge ref_clk);
    endtask

    task automatic do_reset(input int dh, input int mh, input int nom, input int vl);
        @(posedge ref_clk); #2;
        rst_n = 0;
        cfg_div_half = DIV_W'(dh);
        cfg_nom_half = NOM_W'(nom);
        cfg_valid_len = VAL_W'(vl);
        mon_half = mh;
        mon_en = 1;
        wait_cyc(4 * mh + 4);
        check(los_alarm, 1'b1, "R1");
        @(posedge ref_clk); #2;
        rst_n = 1;
        @(posedge ref_clk); #2;
        check(los_alarm, 1'b1, "R1");
    endtask

    initial begin
        void'($urandom(32'h51A7));
        // Directed: validation interrupted midway, R7
        check_on = 1;
        do_reset(2, 1, 4, 40);
        wait_cyc(30);
        mon_en = 0;
        wait_cyc(12);
        mon_en = 1;
        wait_cyc(120);
        // Directed: exact declare latency, R4
        mon_en = 0;
        wait_cyc(30);
        mon_en = 1;
        wait_cyc(80);
        // Directed: zero settings treated as one, R2 and R6
        do_reset(0, 2, 4, 0);
        wait_cyc(60);
        mon_en = 0;
        wait_cyc(20);
        mon_en = 1;
        wait_cyc(60);
        // Random configurations and dropouts
        for (int sc = 0; sc < 12; sc++) begin
            int dh, mh, nom, vl, thr;
            dh = 1 + int'($urandom_range(3));
            mh = 1 + int'($urandom_range(2));
            nom = dh * 2 * mh;
            vl = int'($urandom_range(60));
            thr = 2 * nom;
            do_reset(dh, mh, nom, vl);
            for (int ph = 0; ph < 8; ph++) begin
                mon_en = 1;
                wait_cyc(int'($urandom_range(vl + 3 * thr + 20)));
                mon_en = 0;
                wait_cyc(int'($urandom_range(2 * thr + 4)));
            end
            mon_en = 1;
            wait_cyc(vl + 3 * thr + 20);
        end
        check_on = 0;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule